// File: doc/BRIEF.md
# Itoh-Tsujii GF(2^m) Field Inverter

This block returns the multiplicative inverse of an element of the binary extension field GF(2^M). Elements are held in polynomial basis, reduced by a trinomial or pentanomial that is fixed at elaboration. The inverse is the power a^(2^M-2). That exponent is M-1 one bits followed by a zero, so the block first builds a^(2^(M-1)-1) with an addition chain and then squares it once more.

The chain walks the bits of M-1 from the most significant bit down. It starts from the operand itself, whose exponent is a single one bit. At each lower bit position, a copy of the running value is squared as many times as the exponent has one bits, then multiplied back into the running value, which doubles the count of ones. When that bit of M-1 is set, the running value is squared once more and multiplied by the saved operand, which adds one more one bit. Squaring uses a combinational squarer and takes one cycle. Each product uses an MSB-first bit-serial multiplier that owns its accumulator and takes M cycles. Only three M-bit working registers are used: the saved operand, the running value and its copy.

Operands arrive on a valid/ready stream and results leave on another one. An operand is accepted only when the unit is idle, and no second operand is accepted until the result has been taken. While the downstream side holds `out_ready` low, the result stays on the output port and the unit stalls. Neither side has a FIFO, so back-pressure on the output propagates directly to the input.

Top module: `gf_itoh_inverter`

## Requirements
- R1: An operand is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no operand is in flight and no result is waiting.
- R2: From acceptance until the result is taken, `in_ready` stays low. Any `in_valid`/`in_data` activity in that window has no effect on the result.
- R3: For a nonzero operand a, `out_data` equals a^(2^M-2), so a·out_data = 1 in GF(2^M) modulo x^M + POLY. POLY holds the low M coefficients, and bit i is the coefficient of x^i.
- R4: A zero operand produces `out_valid` with `out_data` = 0 on the cycle right after acceptance.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged.
- R6: After the result is taken, `out_data` keeps its value and `out_valid` stays low until a new operand is accepted.
- R7: After reset, `in_ready` is 1 and `out_valid` is 0.
- R8: Each field product takes exactly M multiplier cycles. The number of cycles from acceptance to `out_valid` is therefore the same for every nonzero operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Unit idle and able to take an operand |
| in_data | input | M | Field element to invert |
| out_valid | output | 1 | Inverse present on `out_data` |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | M | Inverse (zero for a zero operand) |

## Verification
The hardest case to reach from the ports is a chain that runs through every combination of doubling and increment steps, with the serial product wrapping through reduction many times. A small field (M = 7) is therefore swept over every nonzero element, and each product of operand and result is checked against 1. At M = 163, a table of operands with extreme bit patterns (one, x, x^162, all ones) is combined with random operands and compared to a bench-side square-and-multiply exponentiation. The two stream corners are reached by driving the bench directly: new operand traffic is offered while a chain is running, and `out_ready` is held low for many cycles once the result appears.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NEXT,
    ST_DSQ,
    ST_DGO,
    ST_DWAIT,
    ST_ISQ,
    ST_IGO,
    ST_IWAIT,
    ST_STEP,
    ST_FIN,
    ST_DONE
  } inv_state_t;

endpackage

// File: rtl/gf_sqr_comb.sv
module gf_sqr_comb #(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);
  localparam int WW = 2 * M - 1;

  logic [WW-1:0] spread;
  logic [WW-1:0] work;

  for (genvar gi = 0; gi < M; gi++) begin : g_even
    assign spread[2*gi] = a[gi];
  end
  for (genvar gi = 0; gi < M - 1; gi++) begin : g_odd
    assign spread[2*gi+1] = 1'b0;
  end

  // fold each coefficient above x^(M-1) back using x^M = POLY
  always_comb begin
    work = spread;
    for (int i = WW - 1; i >= M; i--) begin
      if (work[i]) begin
        work[i - M +: M] = work[i - M +: M] ^ POLY;
      end
    end
    y = work[M-1:0];
  end

endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] prod
);
  localparam int IW = $clog2(M);
  localparam int RW = $clog2(M + 1);

  logic [IW-1:0] idx;
  logic [M-1:0]  acc;
  logic [M-1:0]  shifted;
  logic [M-1:0]  next_acc;

  // MSB-first: acc*x mod f, then add op_a where op_b has a one
  always_comb begin
    shifted  = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
    next_acc = shifted ^ (op_b[idx] ? op_a : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc  <= op_b[M-1] ? op_a : '0;
        idx  <= IW'(M - 2);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= next_acc;
        if (idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  assign prod = acc;

  // independent cycle counter used only by the checks below
  logic [RW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (go) run_cnt <= RW'(1);
    else if (busy) run_cnt <= run_cnt + 1'b1;
  end

  p_no_go_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == RW'(M)));

endmodule

// File: rtl/gf_itoh_inverter.sv
module gf_itoh_inverter
  import gf_inv_pkg::*;
#(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_data
);
  localparam int CW = $clog2(M) + 1;
  localparam int TOPBIT = $clog2(M) - 1;
  localparam logic [CW-1:0] CHAIN_LEN = CW'(M - 1);

  inv_state_t    state;
  logic [M-1:0]  r_base;   // saved operand
  logic [M-1:0]  r_run;    // running chain value
  logic [M-1:0]  r_copy;   // copy squared during doubling
  logic [CW-1:0] ones;     // one bits in exponent of r_run
  logic [CW-1:0] sq_left;
  logic [CW-1:0] pos;

  logic [M-1:0] sq_in, sq_out;
  logic         mul_go, mul_busy, mul_done, inc_step;
  logic [M-1:0] mul_a, mul_b, mul_p;

  assign sq_in    = (state == ST_DSQ) ? r_copy : r_run;
  assign inc_step = (state == ST_IGO) || (state == ST_IWAIT);
  assign mul_go   = (state == ST_DGO) || (state == ST_IGO);
  assign mul_a    = inc_step ? r_run  : r_copy;
  assign mul_b    = inc_step ? r_base : r_run;

  gf_sqr_comb #(.M(M), .POLY(POLY)) u_sqr (
    .a (sq_in),
    .y (sq_out)
  );

  gf_mul_serial #(.M(M), .POLY(POLY)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (mul_go),
    .op_a  (mul_a),
    .op_b  (mul_b),
    .busy  (mul_busy),
    .done  (mul_done),
    .prod  (mul_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_base  <= '0;
      r_run   <= '0;
      r_copy  <= '0;
      ones    <= '0;
      sq_left <= '0;
      pos     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          if (in_data == '0) begin
            r_run <= '0;
            state <= ST_DONE;
          end else begin
            r_base <= in_data;
            r_run  <= in_data;
            ones   <= CW'(1);
            pos    <= CW'(TOPBIT - 1);
            state  <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          r_copy  <= r_run;
          sq_left <= ones;
          state   <= ST_DSQ;
        end
        ST_DSQ: begin
          r_copy  <= sq_out;
          sq_left <= sq_left - 1'b1;
          if (sq_left == CW'(1)) state <= ST_DGO;
        end
        ST_DGO: state <= ST_DWAIT;
        ST_DWAIT: if (mul_done) begin
          r_run <= mul_p;
          ones  <= ones << 1;
          state <= CHAIN_LEN[pos] ? ST_ISQ : ST_STEP;
        end
        ST_ISQ: begin
          r_run <= sq_out;
          state <= ST_IGO;
        end
        ST_IGO: state <= ST_IWAIT;
        ST_IWAIT: if (mul_done) begin
          r_run <= mul_p;
          ones  <= ones + 1'b1;
          state <= ST_STEP;
        end
        ST_STEP: begin
          if (pos == '0) begin
            state <= ST_FIN;
          end else begin
            pos   <= pos - 1'b1;
            state <= ST_NEXT;
          end
        end
        ST_FIN: begin
          r_run <= sq_out;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_data  = r_run;

  p_accept_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_busy_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mul_busy |-> !in_ready);
  p_ones_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= CHAIN_LEN);
  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data == '0) |=> (out_valid && out_data == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_data));

endmodule

// File: tb/test_gf_itoh_inverter.sv
module test_gf_itoh_inverter;
  localparam int CLK_PERIOD = 10;
  localparam int SM = 7;
  localparam logic [SM-1:0] SPOLY = 7'h03;
  localparam int WM = 163;
  localparam logic [WM-1:0] WPOLY = 163'hC9;
  localparam int NV = 5;
  localparam logic [WM-1:0] WVEC [NV] = '{
    163'h1,
    163'h2,
    (163'h1 << 162),
    {163{1'b1}},
    163'h5_A5A5_1234_DEAD_BEEF_0F0F
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic s_iv = 1'b0, s_ir, s_ov, s_or = 1'b0;
  logic [SM-1:0] s_id = '0, s_od;
  logic w_iv = 1'b0, w_ir, w_ov, w_or = 1'b0;
  logic [WM-1:0] w_id = '0, w_od;

  gf_itoh_inverter #(.M(SM), .POLY(SPOLY)) i_gf_itoh_inverter (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir), .in_data(s_id),
    .out_valid(s_ov), .out_ready(s_or), .out_data(s_od)
  );

  gf_itoh_inverter #(.M(WM), .POLY(WPOLY)) i_gf_itoh_inverter_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_iv), .in_ready(w_ir), .in_data(w_id),
    .out_valid(w_ov), .out_ready(w_or), .out_data(w_od)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [WM-1:0] act,
                     input logic [WM-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [SM-1:0] smul(input logic [SM-1:0] a, input logic [SM-1:0] b);
    logic [2*SM-2:0] p = '0;
    for (int i = 0; i < SM; i++) if (b[i]) p = p ^ ((2*SM-1)'(a) << i);
    for (int i = 2*SM-2; i >= SM; i--) if (p[i]) p[i-SM +: SM] = p[i-SM +: SM] ^ SPOLY;
    return p[SM-1:0];
  endfunction

  function automatic logic [WM-1:0] wmul(input logic [WM-1:0] a, input logic [WM-1:0] b);
    logic [2*WM-2:0] p = '0;
    for (int i = 0; i < WM; i++) if (b[i]) p = p ^ ((2*WM-1)'(a) << i);
    for (int i = 2*WM-2; i >= WM; i--) if (p[i]) p[i-WM +: WM] = p[i-WM +: WM] ^ WPOLY;
    return p[WM-1:0];
  endfunction

  // a^(2^M-2) = product of a^(2^i) for i = 1 .. M-1
  function automatic logic [WM-1:0] wref(input logic [WM-1:0] a);
    logic [WM-1:0] r = WM'(1);
    logic [WM-1:0] s = a;
    for (int i = 1; i < WM; i++) begin
      s = wmul(s, s);
      r = wmul(r, s);
    end
    return r;
  endfunction

  task automatic s_run(input logic [SM-1:0] a, output logic [SM-1:0] r, output int lat);
    @(negedge clk);
    s_iv = 1'b1;
    s_id = a;
    while (!s_ir) @(negedge clk);
    @(negedge clk);
    s_iv = 1'b0;
    lat = 1;
    while (!s_ov) begin
      @(negedge clk);
      lat++;
    end
    r = s_od;
    s_or = 1'b1;
    @(negedge clk);
    s_or = 1'b0;
  endtask

  task automatic w_run(input logic [WM-1:0] a, output logic [WM-1:0] r);
    @(negedge clk);
    w_iv = 1'b1;
    w_id = a;
    while (!w_ir) @(negedge clk);
    @(negedge clk);
    w_iv = 1'b0;
    while (!w_ov) @(negedge clk);
    r = w_od;
    w_or = 1'b1;
    @(negedge clk);
    w_or = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [SM-1:0] sr;
    logic [WM-1:0] wr;
    int lat, lat0;
    bit lat_ok, inv_ok, busy_ok, hold_ok;
    lat0 = 0;

    repeat (3) @(negedge clk);
    // R7: reset state
    chk(s_ir == 1'b1 && s_ov == 1'b0, "R7 reset small", WM'({s_ir, s_ov}), WM'(2'b10));
    chk(w_ir == 1'b1 && w_ov == 1'b0, "R7 reset wide", WM'({w_ir, w_ov}), WM'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ir == 1'b1 && s_ov == 1'b0, "R7 after release", WM'({s_ir, s_ov}), WM'(2'b10));

    // R3 and R8: every nonzero element of GF(2^7)
    lat_ok = 1'b1;
    inv_ok = 1'b1;
    for (int a = 1; a < (1 << SM); a++) begin
      s_run(SM'(a), sr, lat);
      if (a == 1) lat0 = lat;
      if (smul(SM'(a), sr) != SM'(1)) begin
        inv_ok = 1'b0;
        chk(1'b0, "R3 small a*inv", WM'(smul(SM'(a), sr)), WM'(1));
      end
      if (lat != lat0) begin
        lat_ok = 1'b0;
        chk(1'b0, "R8 latency", WM'(lat), WM'(lat0));
      end
    end
    chk(inv_ok, "R3 small sweep", '0, '0);
    chk(lat_ok, "R8 constant latency", WM'(lat), WM'(lat0));

    // R4: zero operand
    s_run('0, sr, lat);
    chk(sr == '0, "R4 zero small value", WM'(sr), '0);
    chk(lat == 1, "R4 zero small latency", WM'(lat), WM'(1));

    // R1, R2: traffic offered while busy; R5: back-pressure
    @(negedge clk);
    s_iv = 1'b1;
    s_id = 7'd5;
    while (!s_ir) @(negedge clk);
    @(negedge clk);
    s_id = 7'd9;
    busy_ok = 1'b1;
    while (!s_ov) begin
      if (s_ir) busy_ok = 1'b0;
      @(negedge clk);
    end
    s_iv = 1'b0;
    chk(busy_ok, "R1 in_ready low while busy", WM'(s_ir), '0);
    sr = s_od;
    chk(smul(7'd5, sr) == SM'(1), "R2 result from first operand", WM'(smul(7'd5, sr)), WM'(1));
    hold_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!s_ov || s_od != sr || s_ir) hold_ok = 1'b0;
    end
    chk(hold_ok, "R5 result held under back-pressure", WM'(s_od), WM'(sr));
    s_or = 1'b1;
    @(negedge clk);
    s_or = 1'b0;
    // R6: value kept after handshake
    hold_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (s_ov || s_od != sr || !s_ir) hold_ok = 1'b0;
    end
    chk(hold_ok, "R6 out_data kept after take", WM'(s_od), WM'(sr));

    // R3: wide field, table then random operands
    for (int v = 0; v < NV; v++) begin
      w_run(WVEC[v], wr);
      chk(wr == wref(WVEC[v]), "R3 wide table", wr, wref(WVEC[v]));
      chk(wmul(WVEC[v], wr) == WM'(1), "R3 wide a*inv", wmul(WVEC[v], wr), WM'(1));
    end
    for (int v = 0; v < 3; v++) begin
      logic [WM-1:0] ra;
      ra = WM'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
      if (ra == '0) ra = WM'(3);
      w_run(ra, wr);
      chk(wr == wref(ra), "R3 wide random", wr, wref(ra));
    end
    // R4: wide zero
    w_run('0, wr);
    chk(wr == '0, "R4 zero wide", wr, '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule